// File: doc/BRIEF.md
# Exclusive-Access Atomic Add Engine

This block performs one atomic add on a memory word. A client hands it a word address and a signed 32-bit addend. The block then drives a memory port that can reserve a word while reading it and can later try to write that word back. The write succeeds only if the reservation is still held, and the port returns a status bit that says whether it did.

The engine reads the word with a reserving load and adds the addend to it. It then tries a conditional store of the sum. If the status bit reports that the reservation was lost, the engine throws the sum away, reads the word again and computes a fresh sum. It repeats this until a store reports success. It then pulses a completion flag for one cycle and presents the value it committed. A saturating count of failed stores stays readable after completion, until the next request is accepted. The reservation tracking and the memory are outside this block.

Top module: `atomic_add_engine`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1, and `mem_req_valid`, `done` and `retry_count` are all 0.
- R2: A request is accepted only when `req_ready` is 1, which happens only while idle, and no memory request is issued while idle. `req_valid` raised while the engine is busy has no effect on the address used, the value committed or the number of memory operations.
- R3: The first memory request after acceptance is a reserving load (`mem_req_kind` = 2'b01) to the address latched at acceptance. The address and operand stay fixed for the whole operation.
- R4: The write data of every conditional store (`mem_req_kind` = 2'b10) equals the data of the preceding reserving load plus the latched operand, modulo 2^32, with no overflow indication.
- R5: A conditional-store response with `mem_rsp_status` = 1 causes a new reserving load on the very next cycle. The previous sum is discarded, and `retry_count` increases by one.
- R6: `done` rises only in the cycle after a conditional-store response with `mem_rsp_status` = 0. It stays high for exactly one cycle, and `result` then equals the data that store wrote.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request, including its kind, address and write data, stays unchanged in the next cycle.
- R8: `retry_count` saturates at its maximum value (255 with the default 8-bit width) and does not wrap.
- R9: `retry_count` clears to 0 when a request is accepted and holds its final value after `done` until the next acceptance.
- R10: The engine never issues the plain access kind (`mem_req_kind` = 2'b00). Every issued request is a reserving load or a conditional store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the target |
| req_operand | input | DATA_W | Signed addend |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_kind | output | 2 | 2'b01 reserving load, 2'b10 conditional store, 2'b00 plain access (never used) |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Conditional-store data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | DATA_W | Load data |
| mem_rsp_status | input | 1 | Conditional-store status: 0 committed, 1 failed |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Committed value, valid with `done` |
| retry_count | output | CNT_W | Saturating count of failed conditional stores |

## Verification
The assertions check the port-level rules on every cycle. These rules are:
- a stalled request holds steady;
- only the two exclusive kinds are issued, and nothing is issued while idle;
- acceptance is followed at once by a load to the latched address;
- a failed store is followed at once by a new load;
- `done` follows only a successful store, lasts one cycle and reports the stored data.

The bench scenarios are needed to show the rest. They cover the arithmetic, including wrap-around and negative addends, and counter saturation over hundreds of failures. They also show that a failed attempt really reloads: another agent changes the word between attempts, so the committed value must include that change. Finally, they show that requests raised while busy leave both the memory and the operation counts untouched.

// File: rtl/atx_pkg.sv
// Shared types for the atomic add engine.
// Assumes: the memory port decodes the kind field with the encodings below.
package atx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LDX_REQ  = 3'd1,
        ST_LDX_WAIT = 3'd2,
        ST_STX_REQ  = 3'd3,
        ST_STX_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } atx_state_e;

    typedef enum logic [1:0] {
        MK_PLAIN = 2'b00,
        MK_LDX   = 2'b01,
        MK_STX   = 2'b10
    } atx_kind_e;

endpackage

// File: rtl/atx_req_latch.sv
// Holds the target address and addend of the operation in flight.
// Assumes: accept is high for one cycle, only while the engine is idle.
module atx_req_latch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_operand,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] operand_q
);

    // Capture address and operand when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            operand_q <= '0;
        end else if (accept) begin
            addr_q    <= in_addr;
            operand_q <= in_operand;
        end
    end

endmodule

// File: rtl/atx_sum_unit.sv
// Working register: each load response replaces it with load data plus addend.
// Assumes: sum wraps modulo 2^DATA_W and no carry is reported.
module atx_sum_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rsp,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] sum_q
);

    logic [DATA_W-1:0] sum_next;

    // Wrap-around sum of the fresh load data and the addend.
    always_comb begin
        sum_next = load_data + operand;
    end

    // Overwrite the working value on every load response, dropping any old sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (load_rsp) begin
            sum_q <= sum_next;
        end
    end

endmodule

// File: rtl/atx_retry_ctr.sv
// Saturating counter of failed conditional stores.
// Assumes: clear and incr are never high in the same cycle.
module atx_retry_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear on acceptance; count failures and stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (incr && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/atx_seq_fsm.sv
// Sequencer for the load / add / conditional-store retry loop.
// Assumes: one memory response arrives per accepted memory request,
// and only while the sequencer is waiting for it.
module atx_seq_fsm
    import atx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  logic       mem_rsp_status,
    output logic       accept,
    output logic       load_rsp,
    output logic       stx_fail,
    output logic       idle,
    output logic       mem_req_valid,
    output logic [1:0] mem_req_kind,
    output logic       done
);

    atx_state_e state_q;
    atx_state_e state_d;

    // Event strobes derived from the current state and the port inputs.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        load_rsp = (state_q == ST_LDX_WAIT) && mem_rsp_valid;
        stx_fail = (state_q == ST_STX_WAIT) && mem_rsp_valid && mem_rsp_status;
    end

    // Next-state selection for the retry loop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_LDX_REQ;
            ST_LDX_REQ:  if (mem_req_ready) state_d = ST_LDX_WAIT;
            ST_LDX_WAIT: if (mem_rsp_valid) state_d = ST_STX_REQ;
            ST_STX_REQ:  if (mem_req_ready) state_d = ST_STX_WAIT;
            ST_STX_WAIT: if (mem_rsp_valid) state_d = mem_rsp_status ? ST_LDX_REQ : ST_DONE;
            ST_DONE:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Port-facing decode of the current state.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        done          = (state_q == ST_DONE);
        mem_req_valid = (state_q == ST_LDX_REQ) || (state_q == ST_STX_REQ);
        mem_req_kind  = (state_q == ST_STX_REQ) ? MK_STX : MK_LDX;
    end

endmodule

// File: rtl/atomic_add_engine.sv
// Top of the atomic add engine: latches a request, repeats reserving load,
// add and conditional store until a store commits, then pulses done.
// Assumes: the memory side keeps the reservation and reports store status.
module atomic_add_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_operand,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_kind,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              mem_rsp_status,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [CNT_W-1:0]  retry_count
);

    logic              accept;
    logic              load_rsp;
    logic              stx_fail;
    logic              idle;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] operand_q;
    logic [DATA_W-1:0] sum_q;

    atx_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_status (mem_rsp_status),
        .accept         (accept),
        .load_rsp       (load_rsp),
        .stx_fail       (stx_fail),
        .idle           (idle),
        .mem_req_valid  (mem_req_valid),
        .mem_req_kind   (mem_req_kind),
        .done           (done)
    );

    atx_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_addr    (req_addr),
        .in_operand (req_operand),
        .addr_q     (addr_q),
        .operand_q  (operand_q)
    );

    atx_sum_unit #(.DATA_W(DATA_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_rsp  (load_rsp),
        .load_data (mem_rsp_rdata),
        .operand   (operand_q),
        .sum_q     (sum_q)
    );

    atx_retry_ctr #(.CNT_W(CNT_W)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .incr    (stx_fail),
        .count_q (retry_count)
    );

    // Output wiring: the latched address and the working sum drive the port.
    always_comb begin
        req_ready     = idle;
        mem_req_addr  = addr_q;
        mem_req_wdata = sum_q;
        result        = sum_q;
    end

endmodule

// File: rtl/atx_checker.sv
// Port-level protocol checks for the atomic add engine, bound to its top.
// Assumes: the memory returns one response per accepted request.
module atx_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [1:0]        mem_req_kind,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_status,
    input logic              done,
    input logic [DATA_W-1:0] result
);

    logic              stx_pend;
    logic [DATA_W-1:0] stx_data;

    // Track an outstanding conditional store and the data it carried.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stx_pend <= 1'b0;
            stx_data <= '0;
        end else if (mem_req_valid && mem_req_ready && mem_req_kind == 2'b10) begin
            stx_pend <= 1'b1;
            stx_data <= mem_req_wdata;
        end else if (mem_rsp_valid) begin
            stx_pend <= 1'b0;
        end
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R2

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && mem_req_kind == 2'b01
                                      && mem_req_addr == $past(req_addr))); // R3

    AST_RELOAD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_pend && mem_rsp_valid && mem_rsp_status) |=> (mem_req_valid && mem_req_kind == 2'b01 && !done)); // R5

    AST_DONE_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_pend && mem_rsp_valid && !mem_rsp_status) |=> done); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == stx_data)); // R6

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_kind)
            && $stable(mem_req_addr) && $stable(mem_req_wdata))); // R7

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_kind == 2'b01 || mem_req_kind == 2'b10)); // R10

endmodule

bind atomic_add_engine atx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_atx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_kind   (mem_req_kind),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_status (mem_rsp_status),
    .done           (done),
    .result         (result)
);

// File: tb/test_atomic_add_engine.sv
// Directed bench: a small memory with one reservation monitor, forced store
// failures, interfering writes between attempts, and port stalls.
module test_atomic_add_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_operand = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [1:0]  mem_req_kind;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        mem_rsp_status = 1'b0;
    logic        done;
    logic [31:0] result;
    logic [7:0]  retry_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    // Memory model state.
    logic [31:0] mem [16];
    logic        mon_v = 1'b0;
    logic [31:0] mon_a = '0;
    int          n_ldx = 0;
    int          n_stx = 0;
    int          n_plain = 0;
    int          fail_seen = 0;
    int          fail_target = 0;
    logic [31:0] interf = '0;
    logic [31:0] last_ldx_addr = '0;
    logic        stall_en = 1'b0;
    logic        tgl = 1'b0;
    logic        bd_we = 1'b0;
    logic [3:0]  bd_idx = '0;
    logic [31:0] bd_data = '0;

    always #5 clk = ~clk;

    assign mem_req_ready = stall_en ? tgl : 1'b1;

    atomic_add_engine i_atomic_add_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_operand    (req_operand),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_kind   (mem_req_kind),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_rdata  (mem_rsp_rdata),
        .mem_rsp_status (mem_rsp_status),
        .done           (done),
        .result         (result),
        .retry_count    (retry_count)
    );

    // Memory with a single reservation; fails stores on demand and lets
    // another agent add to the word on each forced failure.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        tgl <= ~tgl;
        if (!rst_n) begin
            mon_v <= 1'b0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            if (bd_we) mem[bd_idx] <= bd_data;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid  <= 1'b1;
                mem_rsp_status <= 1'b0;
                if (mem_req_kind == 2'b01) begin
                    mem_rsp_rdata <= mem[mem_req_addr[5:2]];
                    mon_v         <= 1'b1;
                    mon_a         <= mem_req_addr;
                    last_ldx_addr <= mem_req_addr;
                    n_ldx         <= n_ldx + 1;
                end else if (mem_req_kind == 2'b10) begin
                    n_stx <= n_stx + 1;
                    mon_v <= 1'b0;
                    if (mon_v && mon_a == mem_req_addr && fail_seen >= fail_target) begin
                        mem[mem_req_addr[5:2]] <= mem_req_wdata;
                    end else begin
                        mem_rsp_status <= 1'b1;
                        fail_seen <= fail_seen + 1;
                        mem[mem_req_addr[5:2]] <= mem[mem_req_addr[5:2]] + interf;
                    end
                end else begin
                    n_plain <= n_plain + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic backdoor(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        bd_we = 1'b1; bd_idx = idx; bd_data = val;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    // One complete atomic add with its own checks.
    task automatic run_op(input string name, input logic [3:0] idx, input logic [31:0] init,
                          input logic [31:0] op, input int nfail, input logic [31:0] inter,
                          input bit stall, input bit noise);
        logic [3:0]  nidx = idx ^ 4'h8;
        logic [31:0] exp_val;
        logic [7:0]  exp_cnt;
        int ldx0, stx0, pl0, cyc;
        backdoor(idx, init);
        backdoor(nidx, 32'h5A5A_0000);
        @(negedge clk);
        fail_target = fail_seen + nfail;
        interf = inter;
        stall_en = stall;
        ldx0 = n_ldx; stx0 = n_stx; pl0 = n_plain;
        exp_val = init + op;
        for (int k = 0; k < nfail; k++) exp_val = exp_val + inter;
        exp_cnt = (nfail > 255) ? 8'd255 : 8'(nfail);
        req_valid = 1'b1; req_addr = {26'd0, idx, 2'b00}; req_operand = op;
        @(negedge clk);
        if (noise) begin
            req_addr = {26'd0, nidx, 2'b00}; req_operand = 32'h0000_1111;
        end else begin
            req_valid = 1'b0;
        end
        chk(req_ready == 1'b0, {name, " R2 busy"}, 32'(req_ready), 32'd0);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, {name, " R6 done seen"}, 32'(done), 32'd1);
        chk(result == exp_val, {name, " R4 R6 result"}, result, exp_val);
        chk(retry_count == exp_cnt, {name, " R5 R8 retries"}, 32'(retry_count), 32'(exp_cnt));
        @(negedge clk);
        chk(done == 1'b0, {name, " R6 pulse width"}, 32'(done), 32'd0);
        chk(retry_count == exp_cnt, {name, " R9 count held"}, 32'(retry_count), 32'(exp_cnt));
        chk(req_ready == 1'b1, {name, " R2 idle again"}, 32'(req_ready), 32'd1);
        chk(mem[idx] == exp_val, {name, " R4 memory word"}, mem[idx], exp_val);
        chk(n_ldx - ldx0 == nfail + 1, {name, " R5 load count"}, 32'(n_ldx - ldx0), 32'(nfail + 1));
        chk(n_stx - stx0 == nfail + 1, {name, " R6 store count"}, 32'(n_stx - stx0), 32'(nfail + 1));
        chk(n_plain == pl0, {name, " R10 no plain access"}, 32'(n_plain - pl0), 32'd0);
        chk(last_ldx_addr == {26'd0, idx, 2'b00}, {name, " R3 load address"}, last_ldx_addr, {26'd0, idx, 2'b00});
        if (noise) chk(mem[nidx] == 32'h5A5A_0000, {name, " R2 busy request ignored"}, mem[nidx], 32'h5A5A_0000);
        stall_en = 1'b0;
    endtask

    task automatic check_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(retry_count == 8'd0, "R1 retry_count", 32'(retry_count), 32'd0);
    endtask

    task automatic print_summary;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        print_summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset();
        run_op("plain",     4'd1, 32'd100,        32'd23,         0,   32'd0,  1'b0, 1'b0);
        run_op("wrap",      4'd2, 32'hFFFF_FFF0,  32'h0000_0020,  0,   32'd0,  1'b0, 1'b0);
        run_op("negative",  4'd3, 32'd5,          32'hFFFF_FFF9,  0,   32'd0,  1'b0, 1'b0);
        run_op("retry",     4'd4, 32'd1000,       32'd7,          3,   32'd10, 1'b0, 1'b0);
        run_op("stall",     4'd5, 32'h1234_0000,  32'h0000_5678,  2,   32'd1,  1'b1, 1'b0);
        run_op("noise",     4'd6, 32'd40,         32'd2,          1,   32'd0,  1'b1, 1'b1);
        run_op("saturate",  4'd7, 32'd0,          32'd1,          260, 32'd2,  1'b0, 1'b0);
        run_op("restart",   4'd1, 32'd9,          32'd1,          0,   32'd0,  1'b0, 1'b0);
        print_summary();
        $finish;
    end

endmodule